// File: doc/BRIEF.md
# Adder fault-tolerance controller

This block is the control state machine that sits beside a split (lower half / upper half) carry-lookahead adder. While the host holds `test_req` high, the controller walks the adder through repeated online test passes. A pass runs stuck-at tests on each half, then transition tests on each half, then a path-delay test. For each test the controller pulses `pat_start` to an external pattern source and drives `pat_kind` to say which pattern set is wanted. It then waits for `pat_done`. The adder's comparators report mismatches on `err_lo`, `err_hi` and `err_dly`. The controller records each report only while the test that owns it is running.

A pass ends when the path-delay test finishes, or when any test finishes while `test_req` is low. At that point, if any fault has been recorded, the controller enters a sticky degraded state. The routing mode it then selects depends on the kind of fault:
- A faulty half is removed, and the other half carries the addition alone.
- A delay fault keeps both halves but allows two cycles per addition.
- Faults in both halves fall back to two-cycle operation in the lower half and raise `fatal`.

`slow_req` tells the host to halve its issue rate whenever the adder is not in full-speed mode. Only the synchronous `rst` leaves the degraded state, so that a temporary fault can be forgotten.

States: FUNC (full speed), SA_LO, SA_HI, TR_LO, TR_HI, PD (tests), DEGRADED.

Transitions:
- FUNC→SA_LO when `test_req` is high.
- Within a pass, on `pat_done`: SA_LO→SA_HI→TR_LO→TR_HI→PD.
- At the end of a pass:
  - any test state → DEGRADED if a fault is recorded;
  - otherwise PD→SA_LO if `test_req` is still high;
  - otherwise → FUNC.
- DEGRADED→DEGRADED until `rst`.
- `rst` returns every state to FUNC.

Top module: `adft_ctrl`

## Requirements
- R1: One clock after `rst` is high: `mode` is 0, and `slow_req`, `fatal` and `pat_start` are all 0.
- R2: With `test_req` high in FUNC, the tests run in this order, each entered one clock after the previous test's `pat_done` cycle:
  - SA_LO: mode 1, kind 0
  - SA_HI: mode 2, kind 0
  - TR_LO: mode 1, kind 1
  - TR_HI: mode 2, kind 1
  - PD: mode 3, kind 2
  
  `pat_start` is high for exactly the first cycle of each test.
- R3: When PD finishes with `test_req` high and no fault recorded, a new pass starts at SA_LO (mode 1, `pat_start` high).
- R4: When any test finishes with `test_req` low and no fault recorded, the controller returns to FUNC (mode 0, `slow_req` low).
- R5: `err_lo` seen during SA_LO or TR_LO leaves the controller, at the end of the pass, in mode 5 (upper half only).
- R6: `err_hi` seen during SA_HI or TR_HI leaves the controller, at the end of the pass, in mode 4 (lower half only).
- R7: `err_dly` seen during PD leaves the controller, at the end of the pass, in mode 6 (both halves, two cycles per addition).
- R8: Faults recorded in both halves give mode 7 (lower half, two cycles) with `fatal` high. `fatal` is low in every other case.
- R9: A half fault takes priority over a delay fault when both are recorded.
- R10: An error flag asserted outside the test that owns it, including in FUNC, has no effect on `mode`.
- R11: `slow_req` is high in every mode except 0.
- R12: Once degraded, `mode` and `fatal` hold and `pat_start` stays low, whatever `test_req` does.
- R13: `rst` clears every recorded fault and returns a degraded controller to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear of state and recorded faults |
| test_req | input | 1 | Host request to run online test passes |
| err_lo | input | 1 | Mismatch reported for the lower half |
| err_hi | input | 1 | Mismatch reported for the upper half |
| err_dly | input | 1 | Mismatch reported by the path-delay check |
| pat_done | input | 1 | Pattern source has finished the current test |
| mode | output | 3 | Adder routing code (0 full, 1/2/3 test lower/upper/delay, 4 lower only, 5 upper only, 6 two-cycle, 7 lower two-cycle) |
| pat_start | output | 1 | One-cycle start pulse to the pattern source |
| pat_kind | output | 2 | Pattern set wanted: 0 stuck-at, 1 transition, 2 path-delay, 3 none |
| slow_req | output | 1 | Host must halve its input rate |
| fatal | output | 1 | Both halves are faulty |

## Verification
The hardest situation to reach is the fatal fallback, together with the priority rules between fault kinds. These need faults on different flags, placed in different tests of one pass, that survive to the pass end. The bench sweeps every placement of a lower fault (none, stuck-at test, transition test) against every placement of an upper fault, with and without a delay fault. It runs each combination once cleanly and once with decoy errors raised in every test that does not own them. The expected mode and `fatal` are computed arithmetically from the placement.

// File: rtl/adft_pkg.sv
package adft_pkg;

    localparam int MODE_W    = 3;
    localparam int KIND_W    = 2;
    localparam int NUM_FLAGS = 3;
    localparam int STATE_W   = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_FUNC  = 3'd0,
        ST_SA_LO = 3'd1,
        ST_SA_HI = 3'd2,
        ST_TR_LO = 3'd3,
        ST_TR_HI = 3'd4,
        ST_PD    = 3'd5,
        ST_DEGR  = 3'd6
    } ctl_state_e;

    typedef enum logic [MODE_W-1:0] {
        MD_FULL    = 3'd0,
        MD_TST_LO  = 3'd1,
        MD_TST_HI  = 3'd2,
        MD_TST_PD  = 3'd3,
        MD_ONLY_LO = 3'd4,
        MD_ONLY_HI = 3'd5,
        MD_TWO_CYC = 3'd6,
        MD_LO_TWO  = 3'd7
    } route_mode_e;

    typedef enum logic [KIND_W-1:0] {
        PK_STUCK = 2'd0,
        PK_TRANS = 2'd1,
        PK_PDLY  = 2'd2,
        PK_IDLE  = 2'd3
    } pat_kind_e;

    // bit order: lo is the MSB, dly the LSB
    typedef struct packed {
        logic lo;
        logic hi;
        logic dly;
    } fault_flags_t;

    function automatic logic is_test_st(ctl_state_e s);
        return (s == ST_SA_LO) || (s == ST_SA_HI) || (s == ST_TR_LO) ||
               (s == ST_TR_HI) || (s == ST_PD);
    endfunction

endpackage

// File: rtl/adft_fault_latch.sv
module adft_fault_latch
    import adft_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  ctl_state_e   state,
    input  logic         err_lo,
    input  logic         err_hi,
    input  logic         err_dly,
    output fault_flags_t flags_q,
    output fault_flags_t flags_nx
);

    logic [NUM_FLAGS-1:0] err_v;
    logic [NUM_FLAGS-1:0] arm_v;
    logic [NUM_FLAGS-1:0] q_v;
    logic [NUM_FLAGS-1:0] nx_v;

    assign err_v = {err_lo, err_hi, err_dly};

    // a flag is only trusted while its owning test is running
    always_comb begin
        arm_v[2] = (state == ST_SA_LO) || (state == ST_TR_LO);
        arm_v[1] = (state == ST_SA_HI) || (state == ST_TR_HI);
        arm_v[0] = (state == ST_PD);
    end

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            logic q_r;
            assign nx_v[i] = q_r | (err_v[i] & arm_v[i]);
            always_ff @(posedge clk) begin
                if (rst) q_r <= 1'b0;
                else     q_r <= nx_v[i];
            end
            assign q_v[i] = q_r;
        end
    endgenerate

    assign flags_q  = fault_flags_t'(q_v);
    assign flags_nx = fault_flags_t'(nx_v);

endmodule

// File: rtl/adft_seq.sv
module adft_seq
    import adft_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         test_req,
    input  logic         pat_done,
    input  fault_flags_t flags_nx,
    output ctl_state_e   state,
    output logic         pat_start
);

    ctl_state_e state_q;
    ctl_state_e state_nx;
    logic       any_fault;
    logic       pass_end;

    assign any_fault = |flags_nx;
    assign pass_end  = pat_done && (!test_req || (state_q == ST_PD));

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FUNC: begin
                if (test_req) state_nx = ST_SA_LO;
            end
            ST_SA_LO, ST_SA_HI, ST_TR_LO, ST_TR_HI, ST_PD: begin
                if (pass_end) begin
                    if (any_fault)     state_nx = ST_DEGR;
                    else if (test_req) state_nx = ST_SA_LO;
                    else               state_nx = ST_FUNC;
                end else if (pat_done) begin
                    unique case (state_q)
                        ST_SA_LO: state_nx = ST_SA_HI;
                        ST_SA_HI: state_nx = ST_TR_LO;
                        ST_TR_LO: state_nx = ST_TR_HI;
                        ST_TR_HI: state_nx = ST_PD;
                        default:  state_nx = ST_PD;
                    endcase
                end
            end
            ST_DEGR: state_nx = ST_DEGR;
            default: state_nx = ST_FUNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_FUNC;
            pat_start <= 1'b0;
        end else begin
            state_q   <= state_nx;
            pat_start <= is_test_st(state_nx) && (state_nx != state_q);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/adft_route_dec.sv
module adft_route_dec
    import adft_pkg::*;
(
    input  ctl_state_e        state,
    input  fault_flags_t      flags_q,
    output logic [MODE_W-1:0] mode,
    output logic [KIND_W-1:0] pat_kind,
    output logic              slow_req,
    output logic              fatal
);

    route_mode_e md;
    pat_kind_e   pk;

    always_comb begin
        md = MD_FULL;
        pk = PK_IDLE;
        unique case (state)
            ST_FUNC:  begin md = MD_FULL;   pk = PK_IDLE;  end
            ST_SA_LO: begin md = MD_TST_LO; pk = PK_STUCK; end
            ST_SA_HI: begin md = MD_TST_HI; pk = PK_STUCK; end
            ST_TR_LO: begin md = MD_TST_LO; pk = PK_TRANS; end
            ST_TR_HI: begin md = MD_TST_HI; pk = PK_TRANS; end
            ST_PD:    begin md = MD_TST_PD; pk = PK_PDLY;  end
            ST_DEGR: begin
                pk = PK_IDLE;
                if (flags_q.lo && flags_q.hi) md = MD_LO_TWO;
                else if (flags_q.lo)          md = MD_ONLY_HI;
                else if (flags_q.hi)          md = MD_ONLY_LO;
                else                          md = MD_TWO_CYC;
            end
            default: begin md = MD_FULL; pk = PK_IDLE; end
        endcase
    end

    assign mode     = md;
    assign pat_kind = pk;
    assign slow_req = (state != ST_FUNC);
    assign fatal    = (state == ST_DEGR) && flags_q.lo && flags_q.hi;

endmodule

// File: rtl/adft_ctrl.sv
module adft_ctrl
    import adft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_req,
    input  logic              err_lo,
    input  logic              err_hi,
    input  logic              err_dly,
    input  logic              pat_done,
    output logic [MODE_W-1:0] mode,
    output logic              pat_start,
    output logic [KIND_W-1:0] pat_kind,
    output logic              slow_req,
    output logic              fatal
);

    ctl_state_e   state;
    fault_flags_t flags_q;
    fault_flags_t flags_nx;

    adft_fault_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .err_lo   (err_lo),
        .err_hi   (err_hi),
        .err_dly  (err_dly),
        .flags_q  (flags_q),
        .flags_nx (flags_nx)
    );

    adft_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .test_req  (test_req),
        .pat_done  (pat_done),
        .flags_nx  (flags_nx),
        .state     (state),
        .pat_start (pat_start)
    );

    adft_route_dec u_dec (
        .state    (state),
        .flags_q  (flags_q),
        .mode     (mode),
        .pat_kind (pat_kind),
        .slow_req (slow_req),
        .fatal    (fatal)
    );

endmodule

// File: rtl/adft_ctrl_chk.sv
module adft_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       test_req,
    input logic [2:0] mode,
    input logic       pat_start,
    input logic       slow_req,
    input logic       fatal
);

    // R1: clear one clock after rst
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (mode == 3'd0 && !fatal && !pat_start && !slow_req));

    // R2: start pulse lasts one cycle
    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        pat_start |=> !pat_start);

    // R2: start only in a test mode
    a_r2_start_in_test: assert property (@(posedge clk) disable iff (rst)
        pat_start |-> (mode == 3'd1 || mode == 3'd2 || mode == 3'd3));

    // R8: fatal comes with the lower two-cycle fallback
    a_r8_fatal_mode: assert property (@(posedge clk) disable iff (rst)
        fatal |-> (mode == 3'd7));

    // R11: slow request outside full speed
    a_r11_slow_req: assert property (@(posedge clk) disable iff (rst)
        (mode != 3'd0) |-> slow_req);

    // R12: degraded mode is sticky and issues no starts
    a_r12_degr_hold: assert property (@(posedge clk) disable iff (rst)
        (mode >= 3'd4) |=> (mode == $past(mode) && !pat_start && $stable(fatal)));

    // R2: leaving full speed needs a test request
    a_r2_enter_needs_req: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 && !test_req) |=> (mode == 3'd0));

endmodule

bind adft_ctrl adft_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .test_req  (test_req),
    .mode      (mode),
    .pat_start (pat_start),
    .slow_req  (slow_req),
    .fatal     (fatal)
);

// File: tb/adft_ctrl_tb.sv
`timescale 1ns/1ps
module adft_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_req = 1'b0;
    logic       err_lo = 1'b0;
    logic       err_hi = 1'b0;
    logic       err_dly = 1'b0;
    logic       pat_done = 1'b0;
    logic [2:0] mode;
    logic       pat_start;
    logic [1:0] pat_kind;
    logic       slow_req;
    logic       fatal;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adft_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .test_req  (test_req),
        .err_lo    (err_lo),
        .err_hi    (err_hi),
        .err_dly   (err_dly),
        .pat_done  (pat_done),
        .mode      (mode),
        .pat_start (pat_start),
        .pat_kind  (pat_kind),
        .slow_req  (slow_req),
        .fatal     (fatal)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; test_req = 1'b0; pat_done = 1'b0;
        err_lo = 1'b0; err_hi = 1'b0; err_dly = 1'b0;
        step();
        rst = 1'b0;
        chk("R1 mode", int'(mode), 0);
        chk("R1 slow_req", int'(slow_req), 0);
        chk("R1 fatal", int'(fatal), 0);
        chk("R1 pat_start", int'(pat_start), 0);
    endtask

    // ph: 0 SA_LO, 1 SA_HI, 2 TR_LO, 3 TR_HI, 4 PD
    task automatic run_phase(input int ph, input bit i_lo, input bit i_hi,
                             input bit i_d, input bit decoy, input bit keep);
        int exp_mode;
        int exp_kind;
        exp_mode = (ph == 4) ? 3 : ((ph % 2 == 0) ? 1 : 2);
        exp_kind = (ph == 4) ? 2 : ph / 2;
        chk("R2 test mode", int'(mode), exp_mode);
        chk("R2 pat_kind", int'(pat_kind), exp_kind);
        chk("R2 pat_start first cycle", int'(pat_start), 1);
        chk("R11 slow_req in test", int'(slow_req), 1);
        step();
        chk("R2 pat_start single", int'(pat_start), 0);
        // R10: decoys drive the flags that this test does not own
        err_lo  = i_lo | (decoy && !(ph == 0 || ph == 2));
        err_hi  = i_hi | (decoy && !(ph == 1 || ph == 3));
        err_dly = i_d  | (decoy && ph != 4);
        step();
        err_lo = 1'b0; err_hi = 1'b0; err_dly = 1'b0;
        pat_done = 1'b1;
        test_req = keep;
        step();
        pat_done = 1'b0;
    endtask

    initial begin
        step();
        for (int lp = 0; lp < 3; lp++) begin
            for (int hp = 0; hp < 3; hp++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int dc = 0; dc < 2; dc++) begin
                        bit lo_f, hi_f, any_f;
                        int exp_m;
                        lo_f  = (lp != 0);
                        hi_f  = (hp != 0);
                        any_f = lo_f | hi_f | (d != 0);
                        if (lo_f && hi_f) exp_m = 7;
                        else if (lo_f)    exp_m = 5;
                        else if (hi_f)    exp_m = 4;
                        else if (d != 0)  exp_m = 6;
                        else              exp_m = 0;
                        do_reset();
                        if (dc != 0) begin
                            err_lo = 1'b1; err_hi = 1'b1; err_dly = 1'b1;
                            step();
                            step();
                            err_lo = 1'b0; err_hi = 1'b0; err_dly = 1'b0;
                            chk("R10 errors ignored in full speed", int'(mode), 0);
                        end
                        test_req = 1'b1;
                        step();
                        run_phase(0, lp == 1, 1'b0, 1'b0, dc != 0, 1'b1);
                        run_phase(1, 1'b0, hp == 1, 1'b0, dc != 0, 1'b1);
                        run_phase(2, lp == 2, 1'b0, 1'b0, dc != 0, 1'b1);
                        run_phase(3, 1'b0, hp == 2, 1'b0, dc != 0, 1'b1);
                        run_phase(4, 1'b0, 1'b0, d != 0, dc != 0, 1'b1);
                        if (!any_f) begin
                            chk("R3 new pass mode", int'(mode), 1);
                            chk("R3 new pass start", int'(pat_start), 1);
                            run_phase(0, 1'b0, 1'b0, 1'b0, dc != 0, 1'b0);
                            chk("R4 back to full speed", int'(mode), 0);
                            chk("R11 slow_req low in full", int'(slow_req), 0);
                            chk("R10 decoys left no fault", int'(fatal), 0);
                        end else begin
                            chk("R5 R6 R7 R8 R9 degraded mode", int'(mode), exp_m);
                            chk("R8 fatal", int'(fatal), (lo_f && hi_f) ? 1 : 0);
                            chk("R11 slow_req degraded", int'(slow_req), 1);
                            test_req = 1'b0;
                            step();
                            step();
                            test_req = 1'b1;
                            step();
                            chk("R12 no start when degraded", int'(pat_start), 0);
                            step();
                            chk("R12 mode held", int'(mode), exp_m);
                            chk("R12 fatal held", int'(fatal), (lo_f && hi_f) ? 1 : 0);
                            test_req = 1'b0;
                            rst = 1'b1;
                            step();
                            rst = 1'b0;
                            chk("R13 mode cleared", int'(mode), 0);
                            chk("R13 fatal cleared", int'(fatal), 0);
                            step();
                            chk("R13 stays full speed", int'(mode), 0);
                        end
                    end
                end
            end
        end
        // R4: request dropped in the middle of a pass
        do_reset();
        test_req = 1'b1;
        step();
        run_phase(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_phase(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 mid-pass drop to full", int'(mode), 0);
        chk("R4 slow_req low", int'(slow_req), 0);
        // R5: fault then request dropped early still degrades
        test_req = 1'b1;
        step();
        run_phase(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 early end degrades upper-only", int'(mode), 5);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule